// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block takes one parallel data word per request and shifts it out on a single serial line as an asynchronous frame. A frame has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional odd or even parity bit, then a high stop period. The stop period lasts 1, 1.5 or 2 bit times. While nothing is being sent, the line stays high.

A run-time divisor sets bit timing. The divisor is the number of system clocks per oversampling tick, and sixteen ticks make one bit, so the 1.5-bit stop period is exactly 24 ticks. Words enter through a valid/ready handshake. Data, length, parity mode, stop length and divisor are all captured when a word is accepted, and they stay fixed for that frame. Ready stays low, and busy stays high, until the last stop tick has elapsed. The block accepts the next word in the first cycle after that, so frames can follow each other with no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx` is 1, `s_ready` is 1 and `busy` is 0.
- R2: A word is accepted at a clock edge where `s_valid` and `s_ready` are both 1. From the next cycle, `tx` drives the start bit low for 16 ticks.
- R3: The number of data bits is 5 + `cfg_len` (`cfg_len` = 0..3 gives 5..8 bits). The bits are sent least significant bit first, each for 16 ticks, and data bits above that length are not sent.
- R4: One tick lasts `cfg_div` system clocks, with 0 treated as 1, so each bit time is 16 × `cfg_div` clocks.
- R5: `cfg_parity` = 1 selects odd parity and 2 selects even parity; 0 and 3 send no parity bit. The parity bit follows the last data bit for 16 ticks, and it makes the count of ones over the sent data bits plus the parity bit odd (mode 1) or even (mode 2).
- R6: The stop period is driven high for 16 ticks when `cfg_stop` = 0, for 24 ticks when it is 1, and for 32 ticks when it is 2 or 3.
- R7: `s_ready` is 0 and `busy` is 1 from the cycle after acceptance until the last stop tick has elapsed. A word presented with `s_valid` during that time is not accepted and does not change the frame in progress.
- R8: `s_ready` returns to 1 in the cycle right after the last stop tick. A word accepted at the next edge starts its start bit with no idle cycle between frames.
- R9: Data and all configuration inputs are sampled at acceptance. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Word offered |
| s_ready | output | 1 | Transmitter can accept a word |
| s_data | input | 8 | Word to send, LSB first |
| cfg_len | input | 2 | Data length code: 5 + value bits |
| cfg_parity | input | 2 | 0/3 none, 1 odd, 2 even |
| cfg_stop | input | 2 | 0: 1 bit, 1: 1.5 bits, 2/3: 2 bits |
| cfg_div | input | DIV_W | System clocks per 1/16 bit (0 acts as 1) |
| tx | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with `DIV_W` = 4 and the default 16-tick oversampling. With these values every divisor code from 0 up to the maximum 15 can be applied, including the zero-as-one case. At divisor 1, every frame stays short enough to sweep all 64 combinations of length, parity and stop codes back to back. A reference model expands each accepted word into a per-clock list of expected line levels, so every bit boundary and the 24-tick stop period are compared cycle by cycle. Separate runs hold `s_valid` high during a busy frame and change the configuration mid-frame.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int unsigned WORD_W   = 8;
    localparam int unsigned MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;

    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;

    // data length in bits from the 2-bit length code
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction

endpackage

// File: rtl/uft_baud_div.sv
module uft_baud_div #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             last;

    always_comb begin
        last = (div <= DIV_W'(1)) || (cnt_q == div - DIV_W'(1));
        tick = run && !clear && last;
        if (clear || !run) begin
            cnt_d = '0;
        end else if (last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/uft_parity.sv
module uft_parity
    import uft_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic [1:0]        mode,
    output logic              par
);

    logic [WORD_W-1:0] mask;
    logic [3:0]        nbits;
    logic              ones_odd;

    assign nbits = word_bits(len_code);

    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign mask[i] = (nbits > 4'(i));
    end

    always_comb begin
        ones_odd = ^(data & mask);
        if (mode == PAR_ODD) begin
            par = ~ones_odd;
        end else begin
            par = ones_odd;
        end
    end

endmodule

// File: rtl/uft_tx_fsm.sv
module uft_tx_fsm
    import uft_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned OVS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_stop,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              par_in,
    input  logic              tick,
    output logic              accept,
    output logic              idle,
    output logic              tx,
    output logic [DIV_W-1:0]  div_q
);

    localparam int unsigned CNT_W   = $clog2(2 * OVS + 1);
    localparam int unsigned IDX_W   = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] BIT_LIM  = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(OVS + OVS / 2);
    localparam logic [CNT_W-1:0] TWO_LIM  = CNT_W'(2 * OVS);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  tcnt;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] sh;
        logic [3:0]        nbits;
        logic              par_en;
        logic              par_bit;
        logic [1:0]        stop;
        logic [DIV_W-1:0]  div;
        logic              line;
    } fsm_t;

    localparam fsm_t RST_VAL = '{
        st:      ST_IDLE,
        tcnt:    '0,
        idx:     '0,
        sh:      '0,
        nbits:   '0,
        par_en:  1'b0,
        par_bit: 1'b0,
        stop:    '0,
        div:     '0,
        line:    1'b1
    };

    fsm_t             r_d, r_q;
    logic [CNT_W-1:0] lim;
    logic             bit_done;
    logic             last_data;

    always_comb begin
        r_d       = r_q;
        accept    = 1'b0;
        last_data = ({1'b0, r_q.idx} == 4'(r_q.nbits - 4'd1));

        if (r_q.st == ST_STOP) begin
            if (r_q.stop == STOP_ONE) begin
                lim = BIT_LIM;
            end else if (r_q.stop == STOP_ONE_HALF) begin
                lim = HALF_LIM;
            end else begin
                lim = TWO_LIM;
            end
        end else begin
            lim = BIT_LIM;
        end
        bit_done = tick && (r_q.tcnt == lim - CNT_W'(1));

        if (r_q.st == ST_IDLE) begin
            if (s_valid) begin
                accept    = 1'b1;
                r_d.st    = ST_START;
                r_d.tcnt  = '0;
                r_d.idx   = '0;
                r_d.sh    = s_data;
                r_d.nbits = word_bits(cfg_len);
                r_d.par_en  = (cfg_parity == PAR_ODD) || (cfg_parity == PAR_EVEN);
                r_d.par_bit = par_in;
                r_d.stop  = cfg_stop;
                r_d.div   = cfg_div;
                r_d.line  = 1'b0;
            end
        end else if (tick) begin
            if (!bit_done) begin
                r_d.tcnt = r_q.tcnt + CNT_W'(1);
            end else begin
                r_d.tcnt = '0;
                unique case (r_q.st)
                    ST_START: begin
                        r_d.st   = ST_DATA;
                        r_d.line = r_q.sh[0];
                    end
                    ST_DATA: begin
                        if (last_data) begin
                            if (r_q.par_en) begin
                                r_d.st   = ST_PARITY;
                                r_d.line = r_q.par_bit;
                            end else begin
                                r_d.st   = ST_STOP;
                                r_d.line = 1'b1;
                            end
                        end else begin
                            r_d.idx  = r_q.idx + IDX_W'(1);
                            r_d.sh   = r_q.sh >> 1;
                            r_d.line = r_q.sh[1];
                        end
                    end
                    ST_PARITY: begin
                        r_d.st   = ST_STOP;
                        r_d.line = 1'b1;
                    end
                    ST_STOP: begin
                        r_d.st   = ST_IDLE;
                        r_d.line = 1'b1;
                    end
                    default: begin
                        r_d = RST_VAL;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle  = (r_q.st == ST_IDLE);
    assign tx    = r_q.line;
    assign div_q = r_q.div;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_parity,
    input  logic [1:0]       cfg_stop,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tx,
    output logic             busy
);

    logic             tick_w;
    logic             accept_w;
    logic             idle_w;
    logic             par_w;
    logic [DIV_W-1:0] div_q_w;

    uft_parity i_parity (
        .data     (s_data),
        .len_code (cfg_len),
        .mode     (cfg_parity),
        .par      (par_w)
    );

    uft_baud_div #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept_w),
        .run   (!idle_w),
        .div   (div_q_w),
        .tick  (tick_w)
    );

    uft_tx_fsm #(.DIV_W(DIV_W), .OVS(OVS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .cfg_len    (cfg_len),
        .cfg_parity (cfg_parity),
        .cfg_stop   (cfg_stop),
        .cfg_div    (cfg_div),
        .par_in     (par_w),
        .tick       (tick_w),
        .accept     (accept_w),
        .idle       (idle_w),
        .tx         (tx),
        .div_q      (div_q_w)
    );

    assign s_ready = idle_w;
    assign busy    = !idle_w;

endmodule

// File: rtl/uft_tx_chk.sv
module uft_tx_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_ready,
    input logic             tx,
    input logic             busy,
    input logic             tick,
    input logic [DIV_W-1:0] div_q
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    // R7
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (busy && !s_ready));

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);

    // R6
    stop_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx));

    // R9
    divisor_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && div_q > DIV_W'(1)) |=> !tick);

endmodule

bind uart_frame_tx uft_tx_chk #(.DIV_W(DIV_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .tx      (tx),
    .busy    (busy),
    .tick    (tick_w),
    .div_q   (div_q_w)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             s_valid;
    logic             s_ready;
    logic [7:0]       s_data;
    logic [1:0]       cfg_len;
    logic [1:0]       cfg_parity;
    logic [1:0]       cfg_stop;
    logic [DIV_W-1:0] cfg_div;
    logic             tx;
    logic             busy;

    always #5 clk = ~clk;

    uart_frame_tx #(.DIV_W(DIV_W)) i_uart_frame_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_data     (s_data),
        .cfg_len    (cfg_len),
        .cfg_parity (cfg_parity),
        .cfg_stop   (cfg_stop),
        .cfg_div    (cfg_div),
        .tx         (tx),
        .busy       (busy)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    bit    m_acc;
    string scen    = "R1";
    int    exp_lvl[$];
    string exp_tag[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void push(input int lvl, input int ticks, input int d,
                                 input string tag);
        for (int k = 0; k < ticks * d; k++) begin
            exp_lvl.push_back(lvl);
            exp_tag.push_back(tag);
        end
    endfunction

    // expected line level per clock for one frame
    function automatic void build(input logic [7:0] data, input int lc,
                                  input int pc, input int sc, input int dv);
        int d    = (dv == 0) ? 1 : dv;
        int n    = 5 + lc;
        int ones = 0;
        push(0, 16, d, "R2");
        for (int i = 0; i < n; i++) begin
            push(int'(data[i]), 16, d, "R3");
            ones += int'(data[i]);
        end
        if (pc == 1) push((ones % 2 == 0) ? 1 : 0, 16, d, "R5");
        if (pc == 2) push(ones % 2, 16, d, "R5");
        push(1, (sc == 0) ? 16 : (sc == 1) ? 24 : 32, d, "R6");
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_lvl.delete();
            exp_tag.delete();
        end else begin
            m_acc = s_valid && (exp_lvl.size() == 0);
            if (exp_lvl.size() > 0) begin
                void'(exp_lvl.pop_front());
                void'(exp_tag.pop_front());
            end
            if (m_acc) build(s_data, int'(cfg_len), int'(cfg_parity),
                             int'(cfg_stop), int'(cfg_div));
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int    e;
            string tg;
            e  = (exp_lvl.size() > 0) ? exp_lvl[0] : 1;
            tg = (exp_tag.size() > 0) ? exp_tag[0] : "R1";
            check(tx === 1'(e), {tg, " ", scen}, "tx", int'(tx), e);
            check(s_ready === (exp_lvl.size() == 0), {"R7 ", scen}, "s_ready",
                  int'(s_ready), int'(exp_lvl.size() == 0));
            check(busy === (exp_lvl.size() != 0), {"R7 ", scen}, "busy",
                  int'(busy), int'(exp_lvl.size() != 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic send(input logic [7:0] d, input int lc, input int pc,
                        input int sc, input int dv);
        @(negedge clk);
        s_data     = d;
        cfg_len    = 2'(lc);
        cfg_parity = 2'(pc);
        cfg_stop   = 2'(sc);
        cfg_div    = DIV_W'(dv);
        s_valid    = 1'b1;
        while (s_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (s_ready !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n      = 1'b0;
        s_valid    = 1'b0;
        s_data     = '0;
        cfg_len    = '0;
        cfg_parity = '0;
        cfg_stop   = '0;
        cfg_div    = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx === 1'b1, "R1 reset", "tx", int'(tx), 1);
        check(s_ready === 1'b1, "R1 reset", "s_ready", int'(s_ready), 1);
        check(busy === 1'b0, "R1 reset", "busy", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 R5 R6 sweep of all codes at divisor 1, back to back (R8)
        scen = "R3/R5/R6/R8 sweep";
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 4; s++) begin
                    send(8'(8'hA5 ^ (l * 53 + p * 29 + s * 11)), l, p, s, 1);
                end
            end
        end
        wait_idle();

        // R4 divisor values including zero and maximum
        scen = "R4 divisor";
        send(8'h5A, 3, 1, 1, 0);
        send(8'hC3, 1, 2, 0, 2);
        send(8'h71, 2, 1, 1, 3);
        send(8'h9E, 0, 2, 2, 15);
        wait_idle();

        // R9 configuration changed mid-frame
        scen = "R9 resample";
        send(8'h3C, 3, 1, 1, 2);
        @(negedge clk);
        s_data = 8'hFF; cfg_len = 2'd0; cfg_parity = 2'd2;
        cfg_stop = 2'd0; cfg_div = 4'd5;
        wait_idle();

        // R7 word offered while busy is held off
        scen = "R7 hold-off";
        send(8'h96, 2, 2, 2, 2);
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h00; cfg_len = 2'd1;
        while (s_ready !== 1'b1) @(negedge clk);
        s_valid = 1'b0;
        repeat (40) @(negedge clk);

        // R8 two frames with no gap at a larger divisor
        scen = "R8 back-to-back";
        send(8'hE7, 3, 0, 1, 3);
        send(8'h18, 3, 1, 1, 3);
        wait_idle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule